// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservations that give load-linked and store-conditional pairs their atomic meaning. Each completed memory operation is presented on one cycle with a kind, a line address and the identifier of the requester that issued it. A load-linked marks the line as reserved for its requester. A later store-conditional from the same requester succeeds only if that reservation has survived. Any store-conditional, an ordinary store by the owner, or a loss of coherence permission on the line ends the reservation.

One cycle after each operation the block reports a success bit and a write-enable. The surrounding cache uses the write-enable to gate its data update, so a failed store-conditional leaves the line untouched. Reservations live in a small table of entries. Each entry holds a line address, an owner identifier, a reservation bit and a valid bit. A load-linked to a line the table does not yet track takes the entry that was allocated longest ago, with first-in first-out replacement. A line that is not tracked is treated as free of any conflict, so operations on it report success.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op_kind 2'b01) always reports success 1 and write-enable 0. It reserves the line for op_req, replacing any other owner.
- R2: A store-conditional (op_kind 2'b10) to a tracked line reports success 1 only when the line is reserved by the same op_req; otherwise it reports 0.
- R3: Every store-conditional to a tracked line removes its reservation, whether it succeeds or fails.
- R4: An ordinary store (op_kind 2'b11) removes the reservation only when op_req owns it. A store by another requester leaves it intact.
- R5: An invalidation (inv_valid with inv_line) removes the reservation on that line. An invalidation of a different line has no effect.
- R6: Write-enable equals success for a store-conditional, is 1 for an ordinary store, and is 0 for a load-linked and for other operations (op_kind 2'b00). Other operations report success 1.
- R7: A store-conditional to a line with no table entry reports success 1 and write-enable 1.
- R8: When all ENTRIES entries are in use, a load-linked to an untracked line evicts the entry allocated longest ago. Lines that are not evicted stay tracked.
- R9: rsp_valid is 1 exactly in the cycle after an op_valid cycle. When rsp_valid is 0, rsp_success and rsp_wr_en are 0.
- R10: An invalidation in the same cycle as an operation on the same line takes effect first. A store-conditional there fails. A load-linked there still leaves its reservation in place.
- R11: After reset the table is empty and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A completed operation is presented this cycle |
| op_kind | input | 2 | 00 other, 01 load-linked, 10 store-conditional, 11 ordinary store |
| op_line | input | LINE_W | Line address of the operation |
| op_req | input | ID_W | Requester identifier |
| inv_valid | input | 1 | A line loses coherence permission this cycle |
| inv_line | input | LINE_W | Line address of the invalidation |
| rsp_valid | output | 1 | Result for the previous cycle's operation |
| rsp_success | output | 1 | 1 success, 0 failure |
| rsp_wr_en | output | 1 | Data update allowed |

## Verification
An invalidation and an operation can arrive in the same cycle, and on the same line they interact. The bench provokes this on purpose. It sends a store-conditional together with an invalidation of its reserved line, which must fail. It also sends a load-linked together with an invalidation of the same line, and a later store-conditional from the same requester must then succeed. A randomized stretch mixes invalidations with operations over a handful of lines and requesters. A behavioural model that applies the invalidation before the operation judges every response.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_LINK  = 2'b01,
        OP_COND  = 2'b10,
        OP_STORE = 2'b11
    } op_kind_e;
endpackage

// File: rtl/llsc_lookup.sv
module llsc_lookup #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 16
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]              key,
    output logic [ENTRIES-1:0]             hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = valid[g] && (lines[g] == key);
    end
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
    import llsc_pkg::*;
(
    input  op_kind_e kind,
    input  logic     tracked,
    input  logic     owned,
    output logic     success,
    output logic     wr_en
);
    always_comb begin
        success = 1'b1;
        wr_en   = 1'b0;
        unique case (kind)
            OP_LINK:  begin success = 1'b1; wr_en = 1'b0; end
            OP_COND:  begin success = !tracked || owned; wr_en = !tracked || owned; end
            OP_STORE: begin success = 1'b1; wr_en = 1'b1; end
            OP_OTHER: begin success = 1'b1; wr_en = 1'b0; end
            default:  begin success = 1'b1; wr_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 16,
    parameter int ID_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [LINE_W-1:0] op_line,
    input  logic [ID_W-1:0]   op_req,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    output logic              rsp_valid,
    output logic              rsp_success,
    output logic              rsp_wr_en
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]             tbl_valid, tbl_valid_n;
    logic [ENTRIES-1:0]             tbl_lock,  tbl_lock_n;
    logic [ENTRIES-1:0][LINE_W-1:0] tbl_line,  tbl_line_n;
    logic [ENTRIES-1:0][ID_W-1:0]   tbl_owner, tbl_owner_n;
    logic [IDX_W-1:0]               alloc_ptr, alloc_ptr_n;

    logic [ENTRIES-1:0] op_hit, inv_hit, eff_lock;
    logic [IDX_W-1:0]   hit_idx;
    logic               tracked, owned, dec_success, dec_wr;
    op_kind_e           kind;

    assign kind = op_kind_e'(op_kind);

    llsc_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_op_lookup (
        .valid(tbl_valid), .lines(tbl_line), .key(op_line), .hit(op_hit)
    );

    llsc_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_inv_lookup (
        .valid(tbl_valid), .lines(tbl_line), .key(inv_line), .hit(inv_hit)
    );

    // invalidation is applied before the operation is judged
    assign eff_lock = tbl_lock & ~(inv_valid ? inv_hit : '0);

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (op_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    assign tracked = |op_hit;
    assign owned   = tracked && eff_lock[hit_idx] && (tbl_owner[hit_idx] == op_req);

    llsc_decide u_decide (
        .kind(kind), .tracked(tracked), .owned(owned),
        .success(dec_success), .wr_en(dec_wr)
    );

    // next table contents
    always_comb begin
        tbl_valid_n = tbl_valid;
        tbl_lock_n  = eff_lock;
        tbl_line_n  = tbl_line;
        tbl_owner_n = tbl_owner;
        alloc_ptr_n = alloc_ptr;
        if (op_valid) begin
            unique case (kind)
                OP_LINK: begin
                    if (tracked) begin
                        tbl_owner_n[hit_idx] = op_req;
                        tbl_lock_n[hit_idx]  = 1'b1;
                    end else begin
                        tbl_valid_n[alloc_ptr] = 1'b1;
                        tbl_line_n[alloc_ptr]  = op_line;
                        tbl_owner_n[alloc_ptr] = op_req;
                        tbl_lock_n[alloc_ptr]  = 1'b1;
                        alloc_ptr_n = (alloc_ptr == LAST_IDX) ? '0 : alloc_ptr + IDX_W'(1);
                    end
                end
                OP_COND: begin
                    if (tracked) tbl_lock_n[hit_idx] = 1'b0;
                end
                OP_STORE: begin
                    if (owned) tbl_lock_n[hit_idx] = 1'b0;
                end
                OP_OTHER: begin
                end
                default: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_valid <= '0;
            tbl_lock  <= '0;
            tbl_line  <= '0;
            tbl_owner <= '0;
            alloc_ptr <= '0;
        end else begin
            tbl_valid <= tbl_valid_n;
            tbl_lock  <= tbl_lock_n;
            tbl_line  <= tbl_line_n;
            tbl_owner <= tbl_owner_n;
            alloc_ptr <= alloc_ptr_n;
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_success <= 1'b0;
            rsp_wr_en   <= 1'b0;
        end else begin
            rsp_valid   <= op_valid;
            rsp_success <= op_valid && dec_success;
            rsp_wr_en   <= op_valid && dec_wr;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [LINE_W-1:0] op_line,
    input logic              inv_valid,
    input logic [LINE_W-1:0] inv_line,
    input logic              rsp_valid,
    input logic              rsp_success,
    input logic              rsp_wr_en
);
    assert_rsp_follows_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rsp_valid);
    assert_no_rsp_without_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!rsp_valid && !rsp_success && !rsp_wr_en));
    assert_link_succeeds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01) |=> (rsp_success && !rsp_wr_en));
    assert_store_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b11) |=> (rsp_success && rsp_wr_en));
    assert_cond_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b10) |=> (rsp_wr_en == rsp_success));
    assert_other_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00) |=> (rsp_success && !rsp_wr_en));
    assert_inv_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && inv_valid && inv_line == op_line)
        ##1 (op_valid && op_kind == 2'b10 && !inv_valid) |=> rsp_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_line(op_line), .inv_valid(inv_valid), .inv_line(inv_line),
    .rsp_valid(rsp_valid), .rsp_success(rsp_success), .rsp_wr_en(rsp_wr_en)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 4;
    localparam int LINE_W  = 16;
    localparam int ID_W    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_kind = 2'b00;
    logic [LINE_W-1:0] op_line = '0;
    logic [ID_W-1:0]   op_req = '0;
    logic              inv_valid = 1'b0;
    logic [LINE_W-1:0] inv_line = '0;
    logic              rsp_valid, rsp_success, rsp_wr_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state
    bit m_valid [ENTRIES];
    bit m_lock  [ENTRIES];
    int m_line  [ENTRIES];
    int m_own   [ENTRIES];
    int m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_line(op_line), .op_req(op_req), .inv_valid(inv_valid), .inv_line(inv_line),
        .rsp_valid(rsp_valid), .rsp_success(rsp_success), .rsp_wr_en(rsp_wr_en)
    );

    task automatic check(input string tag, input bit ev, input bit es, input bit ew);
        tests++;
        if (rsp_valid !== ev || rsp_success !== es || rsp_wr_en !== ew) begin
            fails++;
            $display("FAIL %s: got v=%b s=%b w=%b expected v=%b s=%b w=%b",
                     tag, rsp_valid, rsp_success, rsp_wr_en, ev, es, ew);
        end
    endtask

    // drive at a falling edge, update the model, compare at the next falling edge
    task automatic step(input bit v, input bit [1:0] k, input int ln, input int rq,
                        input bit iv, input int il, input string tag);
        int hit;
        bit es, ew;
        op_valid = v; op_kind = k; op_line = LINE_W'(ln); op_req = ID_W'(rq);
        inv_valid = iv; inv_line = LINE_W'(il);
        if (iv)
            foreach (m_valid[i]) if (m_valid[i] && m_line[i] == il) m_lock[i] = 0;
        hit = -1;
        foreach (m_valid[i]) if (m_valid[i] && m_line[i] == ln) hit = i;
        es = 1; ew = 0;
        if (v) begin
            case (k)
                2'b01: begin
                    if (hit >= 0) begin m_own[hit] = rq; m_lock[hit] = 1; end
                    else begin
                        m_valid[m_ptr] = 1; m_line[m_ptr] = ln;
                        m_own[m_ptr] = rq; m_lock[m_ptr] = 1;
                        m_ptr = (m_ptr + 1) % ENTRIES;
                    end
                end
                2'b10: begin
                    es = (hit < 0) || (m_lock[hit] && m_own[hit] == rq);
                    ew = es;
                    if (hit >= 0) m_lock[hit] = 0;
                end
                2'b11: begin
                    ew = 1;
                    if (hit >= 0 && m_lock[hit] && m_own[hit] == rq) m_lock[hit] = 0;
                end
                default: ;
            endcase
        end else begin
            es = 0;
        end
        @(negedge clk);
        check(tag, v, es, ew);
    endtask

    initial begin
        foreach (m_valid[i]) begin m_valid[i] = 0; m_lock[i] = 0; m_line[i] = 0; m_own[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset state", 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 0, "R11 idle after reset");
        step(1, 2'b10, 5, 1, 0, 0, "R7 cond on untracked line");
        // R1/R2/R3: foreign cond fails and clears
        step(1, 2'b01, 10, 1, 0, 0, "R1 link");
        step(1, 2'b10, 10, 2, 0, 0, "R2 cond by other requester");
        step(1, 2'b10, 10, 1, 0, 0, "R3 owner cond after cleared");
        step(1, 2'b01, 10, 1, 0, 0, "R1 relink");
        step(0, 2'b00, 0, 0, 0, 0, "R9 gap");
        step(1, 2'b10, 10, 1, 0, 0, "R2 owner cond succeeds");
        step(1, 2'b10, 10, 1, 0, 0, "R3 second cond fails");
        step(1, 2'b01, 10, 3, 0, 0, "R1 link steals");
        step(1, 2'b10, 10, 1, 0, 0, "R1 old owner lost");
        // R4 ordinary stores
        step(1, 2'b01, 20, 3, 0, 0, "R1 link");
        step(1, 2'b11, 20, 4, 0, 0, "R4 store by other");
        step(1, 2'b10, 20, 3, 0, 0, "R4 reservation survives");
        step(1, 2'b01, 20, 3, 0, 0, "R1 link");
        step(1, 2'b11, 20, 3, 0, 0, "R4 store by owner");
        step(1, 2'b10, 20, 3, 0, 0, "R4 owner store cleared");
        // R5 invalidation
        step(1, 2'b01, 30, 2, 0, 0, "R1 link");
        step(0, 2'b00, 0, 0, 1, 31, "R5 unrelated invalidation");
        step(1, 2'b10, 30, 2, 0, 0, "R5 reservation kept");
        step(1, 2'b01, 30, 2, 0, 0, "R1 link");
        step(0, 2'b00, 0, 0, 1, 30, "R5 invalidation");
        step(1, 2'b10, 30, 2, 0, 0, "R5 reservation dropped");
        // R10 same-cycle collisions
        step(1, 2'b01, 40, 1, 0, 0, "R1 link");
        step(1, 2'b10, 40, 1, 1, 40, "R10 cond with invalidation");
        step(1, 2'b01, 40, 1, 1, 40, "R10 link with invalidation");
        step(1, 2'b10, 40, 1, 0, 0, "R10 link survives");
        step(1, 2'b00, 40, 1, 0, 0, "R6 other op");
        // R8 replacement: lines 10,20,30,40 fill the table; 50 evicts 10
        step(1, 2'b01, 50, 5, 0, 0, "R8 link evicts oldest");
        step(1, 2'b10, 10, 6, 0, 0, "R8 evicted line untracked");
        step(1, 2'b10, 20, 6, 0, 0, "R8 remaining line tracked");
        step(1, 2'b10, 50, 5, 0, 0, "R8 new entry reserved");
        // randomized mix
        for (int n = 0; n < 400; n++) begin
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
                 $urandom_range(0, 6), $urandom_range(0, 3),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 6), "R6 random mix");
        end
        step(0, 2'b00, 0, 0, 0, 0, "R9 final idle");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule